// File: doc/BRIEF.md
# Speculative Separable Switch Allocator

This block decides, once per cycle, which virtual channel (VC) at each input port of a five-port router gets to cross the crossbar, and to which output. It has two layers of round-robin arbitration. The input layer picks one VC per input port. The output layer picks one input per output port. All outputs are combinational from the request inputs. The round-robin state is registered.

A head flit may bid for the switch in the same cycle its VC is being allocated. Such a request carries a speculative flag. The VC allocator's result for that cycle arrives on the `va_ok` and `va_port` inputs. A speculative win counts only if VC allocation succeeded and the won output equals the port of the assigned VC. Otherwise the win is dropped and the flit bids again the next cycle. Non-speculative requests hold a VC already: `va_ok` is 1 for them and `va_port` names the port of their held VC. They always beat speculative ones.

Under adaptive routing a speculative request may list several candidate outputs and bid on all of them. Only the one that agrees with the assigned VC can survive. Each surviving grant appears twice:
- as a one-hot VC grant per input port;
- as a one-hot input select per output port, which drives the crossbar.

Top module: `spec_switch_alloc`

## Requirements
- R1: After reset every round-robin pointer gives top priority to index 0 (VC 0 at the input layer, input 0 at the output layer). With no request valid, `in_grant` and `out_sel` are all zero.
- R2: Each input port has at most one VC granted. Each output port selects at most one input. Each input port drives at most one output.
- R3: At an input port, once a grant to VC k is used, VC k+1 (mod NUM_VCS) has top priority among that port's VCs in the next cycle.
- R4: At an output port, once a grant to input j is used, input j+1 (mod NUM_PORTS) has top priority in that output's arbiter for the same request class.
- R5: At an output port, a bid from a non-speculative request always wins over any speculative bid, whatever the pointer state.
- R6: At an input port, a speculative VC is considered only when no VC of that port has a valid non-speculative request.
- R7: A speculative request with `va_ok` = 0 is never granted. If it wins an output, that output selects nothing this cycle.
- R8: A granted request is granted only on the output equal to its one-hot `va_port`, and that output is among its `req_ports` candidates. A speculative winner of another candidate output is dropped, leaving that output idle.
- R9: A dropped speculative win does not move any round-robin pointer. With unchanged requests, the same VC and the same input win again in the next cycle.
- R10: `in_grant` at input i is nonzero exactly when some output selects input i.
- R11: A VC whose `req_valid` bit is 0 is never granted.
- R12: Flat encodings. Request k = i*NUM_VCS + v (input i, VC v) uses bit k of `req_valid`, `req_spec`, `va_ok` and `in_grant`, and bits [k*NUM_PORTS +: NUM_PORTS] of `req_ports` and `va_port`, where bit o means output o. `out_sel` bits [o*NUM_PORTS +: NUM_PORTS] belong to output o, and bit i means input i is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | NUM_PORTS*NUM_VCS | VC has a flit bidding for the switch |
| req_spec | input | NUM_PORTS*NUM_VCS | Bid is speculative (VC allocation in the same cycle) |
| req_ports | input | NUM_PORTS*NUM_VCS*NUM_PORTS | Candidate output mask per VC |
| va_ok | input | NUM_PORTS*NUM_VCS | VC allocation succeeded (held VC for non-speculative) |
| va_port | input | NUM_PORTS*NUM_VCS*NUM_PORTS | One-hot output port of the assigned or held VC |
| in_grant | output | NUM_PORTS*NUM_VCS | One-hot granted VC per input port |
| out_sel | output | NUM_PORTS*NUM_PORTS | One-hot selected input per output port |

## Verification
The bench targets the following corner cases:

- **Speculative bid that loses VC allocation.** A design that failed to drop it would hand the crossbar to a flit with no downstream VC.
- **Adaptive bid that wins a candidate differing from the assigned port.** A design that kept that win would send the flit the wrong way. The bench also checks that this dropped win still blocks a second speculative bidder for the same output in that cycle.
- **Non-speculative priority at both layers.** This is checked with the pointers favouring the speculative side, so an allocator that ignored the class would grant the wrong VC or input.
- **Round-robin rotation at both layers.** The bench walks full rotation sequences, then holds a dropped speculative request for two cycles. A design that advanced its pointers on a dropped grant would let a different VC or input win the second time.

// File: rtl/swa_pkg.sv
// Shared declarations for the speculative switch allocator.
// Assumes nothing beyond the encodings documented in the brief.
package swa_pkg;

    // Request class chosen by an input port in a given cycle.
    typedef enum logic {
        CLS_NONSPEC = 1'b0,
        CLS_SPEC    = 1'b1
    } req_class_e;

endpackage

// File: rtl/swa_rr_arb.sv
// Round-robin arbiter with a registered priority pointer.
// Grants the first requester at or after the pointer. The pointer moves to
// one past the winner only when adv is high in that cycle. This lets a caller
// hold the pointer when a grant ends up unused.
module swa_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    int            win_idx;

    // Pick the first request scanning upward from the pointer, wrapping around.
    always_comb begin
        logic found;
        gnt     = '0;
        win_idx = 0;
        found   = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                win_idx  = idx;
                found    = 1'b1;
            end
        end
    end

    // Move the pointer past the winner when the grant was used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv && (|gnt)) begin
            ptr <= IW'((win_idx + 1) % N);
        end
    end

endmodule

// File: rtl/swa_in_stage.sv
// Input-port layer of the allocator.
// Chooses one VC of this port. It prefers non-speculative requests and falls
// back to speculative ones only when none is valid. For the chosen VC it
// exposes:
//   - its candidate outputs, split by class;
//   - the single output on which a win may be kept (the assigned port, gated
//     by va_ok).
// Assumes va_port is one-hot whenever va_ok is high.
module swa_in_stage
    import swa_pkg::*;
#(
    parameter int NV = 4,
    parameter int NP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NV-1:0]    vld,
    input  logic [NV-1:0]    spec,
    input  logic [NV*NP-1:0] cand,
    input  logic [NV-1:0]    ok,
    input  logic [NV*NP-1:0] vport,
    input  logic             used,
    output logic [NV-1:0]    vc_gnt,
    output logic [NP-1:0]    bid_ns,
    output logic [NP-1:0]    bid_sp,
    output logic [NP-1:0]    hit
);
    logic [NV-1:0] ns_mask;
    logic [NV-1:0] sp_mask;
    logic [NV-1:0] arb_req;
    req_class_e    cls;
    logic [NP-1:0] sel_cand;
    logic [NP-1:0] sel_port;
    logic          sel_ok;

    // Split valid VCs by class and present only the preferred class.
    always_comb begin
        ns_mask = vld & ~spec;
        sp_mask = vld & spec;
        cls     = (|ns_mask) ? CLS_NONSPEC : CLS_SPEC;
        arb_req = (cls == CLS_NONSPEC) ? ns_mask : sp_mask;
    end

    swa_rr_arb #(.N(NV)) u_vc_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (arb_req),
        .adv   (used),
        .gnt   (vc_gnt)
    );

    // Fetch the candidate mask and VC-allocation result of the chosen VC.
    always_comb begin
        sel_cand = '0;
        sel_port = '0;
        sel_ok   = 1'b0;
        for (int v = 0; v < NV; v++) begin
            if (vc_gnt[v]) begin
                sel_cand = cand[v*NP +: NP];
                sel_port = vport[v*NP +: NP];
                sel_ok   = ok[v];
            end
        end
    end

    // Route the bid to the class-specific output arbiters and form the keep mask.
    always_comb begin
        bid_ns = (|vc_gnt && cls == CLS_NONSPEC) ? sel_cand : '0;
        bid_sp = (|vc_gnt && cls == CLS_SPEC)    ? sel_cand : '0;
        hit    = sel_ok ? sel_port : '0;
    end

endmodule

// File: rtl/swa_out_stage.sv
// Output-port layer of the allocator.
// Holds two round-robin arbiters over the inputs, one per request class. The
// speculative winner is used only when no non-speculative bid targets this
// output. The winner is kept only if its keep mask (hit) includes this
// output. Each arbiter advances only when its own winner is kept.
module swa_out_stage #(
    parameter int NI = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NI-1:0] ns_req,
    input  logic [NI-1:0] sp_req,
    input  logic [NI-1:0] hit,
    output logic [NI-1:0] sel
);
    logic [NI-1:0] ns_gnt;
    logic [NI-1:0] sp_gnt;
    logic          use_ns;
    logic          ns_adv;
    logic          sp_adv;

    swa_rr_arb #(.N(NI)) u_ns_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (ns_req),
        .adv   (ns_adv),
        .gnt   (ns_gnt)
    );

    swa_rr_arb #(.N(NI)) u_sp_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (sp_req),
        .adv   (sp_adv),
        .gnt   (sp_gnt)
    );

    // Pick the class winner, drop it when its allocation does not match, set advances.
    always_comb begin
        use_ns = |ns_req;
        sel    = (use_ns ? ns_gnt : sp_gnt) & hit;
        ns_adv = use_ns && (|(ns_gnt & hit));
        sp_adv = !use_ns && (|(sp_gnt & hit));
    end

endmodule

// File: rtl/spec_switch_alloc.sv
// Speculative separable switch allocator, top level.
// Builds one input layer per input port and one output layer per output port.
// It swaps the bid vectors between the two layers and feeds back which inputs
// actually received an output. That feedback advances the input pointers and
// gates the per-VC grant.
// Assumes a square router (NUM_PORTS inputs and outputs) and combinational
// VC-allocation results on va_ok/va_port.
module spec_switch_alloc #(
    parameter int NUM_PORTS = 5,
    parameter int NUM_VCS   = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_PORTS*NUM_VCS-1:0]           req_valid,
    input  logic [NUM_PORTS*NUM_VCS-1:0]           req_spec,
    input  logic [NUM_PORTS*NUM_VCS*NUM_PORTS-1:0] req_ports,
    input  logic [NUM_PORTS*NUM_VCS-1:0]           va_ok,
    input  logic [NUM_PORTS*NUM_VCS*NUM_PORTS-1:0] va_port,
    output logic [NUM_PORTS*NUM_VCS-1:0]           in_grant,
    output logic [NUM_PORTS*NUM_PORTS-1:0]         out_sel
);
    localparam int NP = NUM_PORTS;
    localparam int NV = NUM_VCS;

    logic [NV-1:0] vc_gnt   [NP];
    logic [NP-1:0] bid_ns   [NP];
    logic [NP-1:0] bid_sp   [NP];
    logic [NP-1:0] hit      [NP];
    logic [NP-1:0] ns_col   [NP];
    logic [NP-1:0] sp_col   [NP];
    logic [NP-1:0] hit_col  [NP];
    logic [NP-1:0] sel_o    [NP];
    logic [NP-1:0] in_used;

    for (genvar i = 0; i < NP; i++) begin : g_in
        swa_in_stage #(.NV(NV), .NP(NP)) u_in (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld    (req_valid[i*NV +: NV]),
            .spec   (req_spec[i*NV +: NV]),
            .cand   (req_ports[i*NV*NP +: NV*NP]),
            .ok     (va_ok[i*NV +: NV]),
            .vport  (va_port[i*NV*NP +: NV*NP]),
            .used   (in_used[i]),
            .vc_gnt (vc_gnt[i]),
            .bid_ns (bid_ns[i]),
            .bid_sp (bid_sp[i]),
            .hit    (hit[i])
        );
    end

    // Transpose per-input bid vectors into per-output request vectors.
    for (genvar o = 0; o < NP; o++) begin : g_xpose_o
        for (genvar i = 0; i < NP; i++) begin : g_xpose_i
            assign ns_col[o][i]  = bid_ns[i][o];
            assign sp_col[o][i]  = bid_sp[i][o];
            assign hit_col[o][i] = hit[i][o];
        end
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        swa_out_stage #(.NI(NP)) u_out (
            .clk    (clk),
            .rst_n  (rst_n),
            .ns_req (ns_col[o]),
            .sp_req (sp_col[o]),
            .hit    (hit_col[o]),
            .sel    (sel_o[o])
        );
        assign out_sel[o*NP +: NP] = sel_o[o];
    end

    // Mark inputs that won an output after the keep check.
    always_comb begin
        in_used = '0;
        for (int o = 0; o < NP; o++) begin
            in_used = in_used | sel_o[o];
        end
    end

    // Expose the chosen VC only for inputs whose bid was kept.
    for (genvar i = 0; i < NP; i++) begin : g_gnt
        assign in_grant[i*NV +: NV] = in_used[i] ? vc_gnt[i] : '0;
    end

endmodule

// File: rtl/swa_checker.sv
// Property checker for spec_switch_alloc, attached by bind below.
// Looks only at the top-level ports and checks grant shape, class priority at
// the input layer, and agreement of every grant with VC allocation.
module swa_checker #(
    parameter int NUM_PORTS = 5,
    parameter int NUM_VCS   = 4
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic [NUM_PORTS*NUM_VCS-1:0]           req_valid,
    input logic [NUM_PORTS*NUM_VCS-1:0]           req_spec,
    input logic [NUM_PORTS*NUM_VCS*NUM_PORTS-1:0] req_ports,
    input logic [NUM_PORTS*NUM_VCS-1:0]           va_ok,
    input logic [NUM_PORTS*NUM_VCS*NUM_PORTS-1:0] va_port,
    input logic [NUM_PORTS*NUM_VCS-1:0]           in_grant,
    input logic [NUM_PORTS*NUM_PORTS-1:0]         out_sel
);
    localparam int NP = NUM_PORTS;
    localparam int NV = NUM_VCS;

    logic [NP-1:0] col [NP];

    // Gather, per input, the outputs that select it.
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            col[i] = '0;
            for (int o = 0; o < NP; o++) begin
                col[i][o] = out_sel[o*NP + i];
            end
        end
    end

    for (genvar o = 0; o < NP; o++) begin : g_o
        AST_OUT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(out_sel[o*NP +: NP])); // R2
    end

    for (genvar i = 0; i < NP; i++) begin : g_i
        AST_VC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(in_grant[i*NV +: NV])); // R2
        AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col[i])); // R2
        AST_GNT_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
            (|in_grant[i*NV +: NV]) == (|col[i])); // R10

        for (genvar v = 0; v < NV; v++) begin : g_v
            localparam int K = i*NV + v;
            AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
                in_grant[K] |-> req_valid[K]); // R11
            AST_GNT_NEEDS_VA: assert property (@(posedge clk) disable iff (!rst_n)
                in_grant[K] |-> va_ok[K]); // R7
            AST_PORT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
                in_grant[K] |-> (col[i] == va_port[K*NP +: NP])); // R8
            AST_PORT_IN_CAND: assert property (@(posedge clk) disable iff (!rst_n)
                in_grant[K] |-> (|(col[i] & req_ports[K*NP +: NP]))); // R8
            AST_NS_AT_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
                (in_grant[K] && req_spec[K]) |->
                    !(|(req_valid[i*NV +: NV] & ~req_spec[i*NV +: NV]))); // R6
        end
    end

endmodule

bind spec_switch_alloc swa_checker #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_VCS   (NUM_VCS)
) u_swa_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_spec  (req_spec),
    .req_ports (req_ports),
    .va_ok     (va_ok),
    .va_port   (va_port),
    .in_grant  (in_grant),
    .out_sel   (out_sel)
);

// File: tb/spec_switch_alloc_test.sv
module spec_switch_alloc_test;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 5;
    localparam int V  = 4;
    localparam int NV = 15;
    localparam logic [3:0] NONE = 4'd15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [P*V-1:0]   req_valid, req_spec, va_ok;
    logic [P*V*P-1:0] req_ports, va_port;
    logic [P*V-1:0]   in_grant;
    logic [P*P-1:0]   out_sel;
    logic [P*V-1:0]   exp_g;
    logic [P*P-1:0]   exp_s;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_switch_alloc #(.NUM_PORTS(P), .NUM_VCS(V)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_spec(req_spec),
        .req_ports(req_ports), .va_ok(va_ok), .va_port(va_port),
        .in_grant(in_grant), .out_sel(out_sel)
    );

    // One scenario: up to two requests (a, b) from reset, with expected output ports.
    typedef struct packed {
        logic       aval; logic [2:0] ai; logic [1:0] av; logic asp;
        logic [4:0] acand; logic aok; logic [2:0] ap;
        logic       bval; logic [2:0] bi; logic [1:0] bv; logic bsp;
        logic [4:0] bcand; logic bok; logic [2:0] bp;
        logic [3:0] ea; logic [3:0] eb;
    } vec_t;

    localparam vec_t TABLE [NV] = '{
        // R12 single non-speculative request, input 0 VC 0 to output 2
        '{1'b1,3'd0,2'd0,1'b0,5'b00100,1'b1,3'd2, 1'b0,3'd0,2'd0,1'b0,5'b00000,1'b0,3'd0, 4'd2, NONE},
        // R4 two inputs on output 3, pointer at 0 favours input 1
        '{1'b1,3'd1,2'd0,1'b0,5'b01000,1'b1,3'd3, 1'b1,3'd2,2'd1,1'b0,5'b01000,1'b1,3'd3, 4'd3, NONE},
        // R5 non-speculative input 3 beats speculative input 1 on output 3
        '{1'b1,3'd1,2'd0,1'b1,5'b01000,1'b1,3'd3, 1'b1,3'd3,2'd0,1'b0,5'b01000,1'b1,3'd3, NONE, 4'd3},
        // R6 input 0: non-speculative VC 2 preferred over speculative VC 0
        '{1'b1,3'd0,2'd0,1'b1,5'b00010,1'b1,3'd1, 1'b1,3'd0,2'd2,1'b0,5'b10000,1'b1,3'd4, NONE, 4'd4},
        // R8 adaptive candidates {1,3}, assigned port 3 is kept
        '{1'b1,3'd2,2'd0,1'b1,5'b01010,1'b1,3'd3, 1'b0,3'd0,2'd0,1'b0,5'b00000,1'b0,3'd0, 4'd3, NONE},
        // R8 candidate 1 only, assigned port 3: dropped
        '{1'b1,3'd2,2'd0,1'b1,5'b00010,1'b1,3'd3, 1'b0,3'd0,2'd0,1'b0,5'b00000,1'b0,3'd0, NONE, NONE},
        // R7 speculative with failed VC allocation
        '{1'b1,3'd4,2'd3,1'b1,5'b00001,1'b0,3'd0, 1'b0,3'd0,2'd0,1'b0,5'b00000,1'b0,3'd0, NONE, NONE},
        // R8 input 1 wins output 2 but keeps only 0; output 2 stays idle, input 3 loses
        '{1'b1,3'd1,2'd1,1'b1,5'b00101,1'b1,3'd0, 1'b1,3'd3,2'd0,1'b1,5'b00100,1'b1,3'd2, 4'd0, NONE},
        // R7 input 0 wins output 0 with failed allocation; input 1 blocked
        '{1'b1,3'd0,2'd0,1'b1,5'b00001,1'b0,3'd0, 1'b1,3'd1,2'd0,1'b1,5'b00001,1'b1,3'd0, NONE, NONE},
        // R2 two inputs on separate outputs both served
        '{1'b1,3'd3,2'd2,1'b0,5'b00010,1'b1,3'd1, 1'b1,3'd4,2'd2,1'b0,5'b00100,1'b1,3'd2, 4'd1, 4'd2},
        // R11 fields set but valid low: nothing
        '{1'b0,3'd1,2'd1,1'b0,5'b00100,1'b1,3'd2, 1'b0,3'd2,2'd0,1'b1,5'b00001,1'b1,3'd0, NONE, NONE},
        // R5 non-speculative input 4 beats speculative input 0 at pointer 0
        '{1'b1,3'd0,2'd1,1'b1,5'b00100,1'b1,3'd2, 1'b1,3'd4,2'd0,1'b0,5'b00100,1'b1,3'd2, NONE, 4'd2},
        // R6 speculative VC ignored while non-speculative VC 3 is valid at input 2
        '{1'b1,3'd2,2'd0,1'b1,5'b00001,1'b1,3'd0, 1'b1,3'd2,2'd3,1'b0,5'b00010,1'b1,3'd1, NONE, 4'd1},
        // R8 adaptive non-speculative-free pair: input 1 cand {0,4} port 4, input 2 cand {4} port 4
        '{1'b1,3'd1,2'd2,1'b1,5'b10001,1'b1,3'd4, 1'b1,3'd2,2'd2,1'b1,5'b10000,1'b1,3'd4, 4'd4, NONE},
        // R7 both allocations succeed on different outputs
        '{1'b1,3'd0,2'd3,1'b1,5'b01000,1'b1,3'd3, 1'b1,3'd1,2'd3,1'b1,5'b00010,1'b1,3'd1, 4'd3, 4'd1}
    };

    task automatic clear_inputs();
        req_valid = '0; req_spec = '0; req_ports = '0; va_ok = '0; va_port = '0;
    endtask

    task automatic set_req(int i, int v, logic sp, logic [4:0] cand, logic ok, int port);
        int k;
        k = i*V + v;
        req_valid[k] = 1'b1;
        req_spec[k]  = sp;
        req_ports[k*P +: P] = cand;
        va_ok[k]     = ok;
        va_port[k*P +: P] = P'(1) << port;
    endtask

    task automatic expect_clear();
        exp_g = '0; exp_s = '0;
    endtask

    task automatic expect_grant(int i, int v, int o);
        exp_g[i*V + v] = 1'b1;
        exp_s[o*P + i] = 1'b1;
    endtask

    task automatic check(string tag);
        checks++;
        if (in_grant !== exp_g || out_sel !== exp_s) begin
            fails++;
            $display("FAIL %s: in_grant=%h out_sel=%h expected in_grant=%h out_sel=%h",
                     tag, in_grant, out_sel, exp_g, exp_s);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clear_inputs();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Advance one edge with inputs held, then settle away from the edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    initial begin
        clear_inputs();
        expect_clear();

        // R1: idle after reset
        do_reset();
        #1;
        expect_clear();
        check("R1 idle");

        // Table of from-reset scenarios
        for (int n = 0; n < NV; n++) begin
            do_reset();
            if (TABLE[n].aval) set_req(TABLE[n].ai, TABLE[n].av, TABLE[n].asp,
                                       TABLE[n].acand, TABLE[n].aok, TABLE[n].ap);
            if (TABLE[n].bval) set_req(TABLE[n].bi, TABLE[n].bv, TABLE[n].bsp,
                                       TABLE[n].bcand, TABLE[n].bok, TABLE[n].bp);
            if (TABLE[n].aval) begin
                // same-VC pair is never used; b overrides a only when identical
            end
            #1;
            expect_clear();
            if (TABLE[n].ea != NONE) expect_grant(TABLE[n].ai, TABLE[n].av, TABLE[n].ea);
            if (TABLE[n].eb != NONE) expect_grant(TABLE[n].bi, TABLE[n].bv, TABLE[n].eb);
            check($sformatf("table vector %0d", n));
        end

        // R1/R3: all four VCs of input 0 on output 0 rotate starting from VC 0
        do_reset();
        for (int v = 0; v < V; v++) set_req(0, v, 1'b0, 5'b00001, 1'b1, 0);
        #1;
        for (int s = 0; s < V + 1; s++) begin
            expect_clear();
            expect_grant(0, s % V, 0);
            check($sformatf("R3 VC rotation step %0d", s));
            step();
        end

        // R4: five inputs on output 2 rotate starting from input 0
        do_reset();
        for (int i = 0; i < P; i++) set_req(i, 0, 1'b0, 5'b00100, 1'b1, 2);
        #1;
        for (int s = 0; s < P + 1; s++) begin
            expect_clear();
            expect_grant(s % P, 0, 2);
            check($sformatf("R4 input rotation step %0d", s));
            step();
        end

        // R9: dropped speculative wins must not move pointers
        do_reset();
        set_req(0, 0, 1'b1, 5'b00010, 1'b0, 1);
        set_req(0, 1, 1'b1, 5'b00010, 1'b1, 1);
        set_req(1, 0, 1'b1, 5'b01000, 1'b0, 3);
        set_req(2, 0, 1'b1, 5'b01000, 1'b1, 3);
        #1;
        expect_clear();
        check("R9 first dropped cycle");
        step();
        check("R9 pointers held after drop");
        @(negedge clk);
        va_ok[0*V + 0] = 1'b1;
        va_ok[1*V + 0] = 1'b1;
        #1;
        expect_clear();
        expect_grant(0, 0, 1);
        expect_grant(1, 0, 3);
        check("R9 same winners after allocation succeeds");

        // R5 with speculative pointer moved: output 2 speculative arbiter favours input 1
        do_reset();
        set_req(0, 0, 1'b1, 5'b00100, 1'b1, 2);
        #1;
        step();
        @(negedge clk);
        clear_inputs();
        set_req(1, 0, 1'b1, 5'b00100, 1'b1, 2);
        set_req(0, 1, 1'b0, 5'b00100, 1'b1, 2);
        #1;
        expect_clear();
        expect_grant(0, 1, 2);
        check("R5 non-speculative wins against favoured speculative");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule